// File: doc/BRIEF.md
# Transposable Matrix Store with Skewed Banks

This block holds a square matrix of fixed-width elements (16 by 16 elements of 32 bits by default). In one read cycle it returns either a whole row or a whole column as one wide vector. There is no flat register array behind it. The elements are spread over as many small synchronous RAM banks as the matrix has columns, using a diagonal placement. Element (r, c) lives in bank (r + c) mod 16, at word address r. Because of this placement, every row and every column touch each bank exactly once. A full row or a full column can therefore be fetched with one access per bank.

The write side takes one element per cycle, given as a row, a column and a data word. The read side takes a request flag, a mode bit and an index. During a read, each bank gets its own address from a small mapping stage. A lane rotator then realigns the bank outputs after the RAM stage, so that output lane k always carries element index k of the requested row or column. Read data appears one clock after the request, together with a valid flag. The data holds its value until the next request.

Top module: `tmat_skew_mem`

## Requirements
- R1: A read with `rd_col_mode` = 0 and `rd_index` = r returns element (r, k) on lane k, where lane k is bits [32k+31:32k] of `rd_data`, for every k from 0 to 15.
- R2: A read with `rd_col_mode` = 1 and `rd_index` = c returns element (k, c) on lane k, for every k from 0 to 15.
- R3: `rd_valid` is high in exactly the cycle after a cycle in which `rd_en` was high, and low otherwise.
- R4: A write with `wr_en` high changes only element (`wr_row`, `wr_col`). Every other element keeps its value.
- R5: When a write and a read hit the same element in the same cycle, the read returns the value held before the write.
- R6: While `rst` is high, `rd_valid` goes low at the next clock edge and stays low.
- R7: `rd_data` keeps its value in any cycle that follows a cycle with no read request.
- R8: An element written in one cycle is returned by a read issued in the very next cycle.
- R9: Suppose a row read of index i is followed directly by a column read of the same index, with no write in the first of those cycles. Then lane i of both results is the same diagonal element (i, i).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one element this cycle |
| wr_row | input | 4 | Row of the element to write |
| wr_col | input | 4 | Column of the element to write |
| wr_data | input | 32 | Element value to write |
| rd_en | input | 1 | Read request |
| rd_col_mode | input | 1 | 0 selects a row read, 1 selects a column read |
| rd_index | input | 4 | Row number (row mode) or column number (column mode) |
| rd_valid | output | 1 | Read result present on `rd_data` |
| rd_data | output | 512 | Sixteen 32-bit lanes; lane k carries element index k |

## Verification
The bench fills all 256 elements with a value computed from the row and column, then reads every row and every column twice, each time under a different fill pattern. A wrong bank mapping or a wrong rotation direction would show up as lanes that are scrambled or shifted around the diagonal. A column address computed as index minus bank, instead of bank minus index, would return mirrored rows. The bench also issues a write and a read of the same element in one cycle, and a read in the cycle right after a write. A design with the RAM read placed after the write would return the new value too early. A design with an extra pipeline stage would return stale data or raise valid in the wrong cycle. An idle cycle after each read checks that the output holds and that valid drops.

// File: rtl/tmat_pkg.sv
package tmat_pkg;

   // Read orientation; the encoding matches the rd_col_mode pin.
   typedef enum logic {
      ACC_ROW = 1'b0,
      ACC_COL = 1'b1
   } access_mode_e;

   // True when v is a power of two and at least 2.
   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tmat_bank.sv
// One storage bank: DEPTH words of WIDTH bits, one write port and one
// registered read port. A read issued in the same cycle as a write to the
// same word returns the value held before the write.
module tmat_bank #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata <= '0;
      end else if (re) begin
         rdata <= store[raddr];
      end
   end

endmodule

// File: rtl/tmat_bank_map.sv
// Placement logic: picks the bank that receives a write, and gives each
// bank its read address for the row or column that was requested.
module tmat_bank_map
   import tmat_pkg::*;
#(
   parameter int N_DIM = 16,
   localparam int IW   = $clog2(N_DIM)
) (
   input  logic                wr_en,
   input  logic [IW-1:0]       wr_row,
   input  logic [IW-1:0]       wr_col,
   input  access_mode_e        rd_mode,
   input  logic [IW-1:0]       rd_index,
   output logic [N_DIM-1:0]    bank_we,
   output logic [IW-1:0]       bank_waddr,
   output logic [N_DIM*IW-1:0] bank_raddr
);

   // Diagonal placement: element (r, c) sits in bank (r + c) mod N_DIM.
   logic [IW-1:0] wr_bank;
   assign wr_bank    = wr_row + wr_col;
   assign bank_waddr = wr_row;

   for (genvar b = 0; b < N_DIM; b++) begin : g_bank
      logic [IW-1:0] col_addr;
      assign bank_we[b] = wr_en && (wr_bank == IW'(b));
      // In column mode, bank b holds row (b - c) mod N_DIM of column c.
      assign col_addr   = IW'(b) - rd_index;
      assign bank_raddr[b*IW +: IW] = (rd_mode == ACC_COL) ? col_addr : rd_index;
   end

endmodule

// File: rtl/tmat_lane_rotator.sv
// Circular lane shift. With ROT_UP set, output lane k takes input lane
// (k + amt) mod N_LANES; otherwise it takes lane (k - amt) mod N_LANES.
module tmat_lane_rotator #(
   parameter int N_LANES = 16,
   parameter int LANE_W  = 32,
   parameter bit ROT_UP  = 1'b1,
   localparam int IW     = $clog2(N_LANES)
) (
   input  logic [IW-1:0]             amt,
   input  logic [N_LANES*LANE_W-1:0] din,
   output logic [N_LANES*LANE_W-1:0] dout
);

   logic [LANE_W-1:0] lane_in [N_LANES];

   for (genvar k = 0; k < N_LANES; k++) begin : g_lane
      logic [IW-1:0] src;
      assign lane_in[k] = din[k*LANE_W +: LANE_W];
      if (ROT_UP) begin : g_up
         assign src = IW'(k) + amt;
      end else begin : g_down
         assign src = IW'(k) - amt;
      end
      assign dout[k*LANE_W +: LANE_W] = lane_in[src];
   end

endmodule

// File: rtl/tmat_skew_mem.sv
// Square matrix store that returns a full row or a full column per read.
module tmat_skew_mem
   import tmat_pkg::*;
#(
   parameter int N_DIM  = 16,
   parameter int ELEM_W = 32,
   localparam int IW    = $clog2(N_DIM),
   localparam int VEC_W = N_DIM * ELEM_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_row,
   input  logic [IW-1:0]     wr_col,
   input  logic [ELEM_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              rd_col_mode,
   input  logic [IW-1:0]     rd_index,
   output logic              rd_valid,
   output logic [VEC_W-1:0]  rd_data
);

   initial begin
      assert (is_pow2(N_DIM)) else $error("N_DIM must be a power of two >= 2");
      assert (ELEM_W >= 1)    else $error("ELEM_W must be positive");
   end

   access_mode_e         rd_mode;
   logic [N_DIM-1:0]     bank_we;
   logic [IW-1:0]        bank_waddr;
   logic [N_DIM*IW-1:0]  bank_raddr;
   logic [VEC_W-1:0]     bank_q;
   logic [IW-1:0]        rot_q;
   logic                 valid_q;

   assign rd_mode = access_mode_e'(rd_col_mode);

   tmat_bank_map #(.N_DIM(N_DIM)) u_map (
      .wr_en      (wr_en),
      .wr_row     (wr_row),
      .wr_col     (wr_col),
      .rd_mode    (rd_mode),
      .rd_index   (rd_index),
      .bank_we    (bank_we),
      .bank_waddr (bank_waddr),
      .bank_raddr (bank_raddr)
   );

   for (genvar b = 0; b < N_DIM; b++) begin : g_bank
      tmat_bank #(.DEPTH(N_DIM), .WIDTH(ELEM_W)) u_bank (
         .clk   (clk),
         .rst   (rst),
         .we    (bank_we[b]),
         .waddr (bank_waddr),
         .wdata (wr_data),
         .re    (rd_en),
         .raddr (bank_raddr[b*IW +: IW]),
         .rdata (bank_q[b*ELEM_W +: ELEM_W])
      );
   end

   // Both modes use the request index as the rotation amount: lane k of
   // row r is in bank (k + r), and lane k of column c is in bank (k + c).
   always_ff @(posedge clk) begin
      if (rst) begin
         rot_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= rd_en;
         if (rd_en) begin
            rot_q <= rd_index;
         end
      end
   end

   tmat_lane_rotator #(.N_LANES(N_DIM), .LANE_W(ELEM_W), .ROT_UP(1'b1)) u_rot (
      .amt  (rot_q),
      .din  (bank_q),
      .dout (rd_data)
   );

   assign rd_valid = valid_q;

endmodule

// File: rtl/tmat_skew_mem_chk.sv
module tmat_skew_mem_chk #(
   parameter int N_DIM  = 16,
   parameter int ELEM_W = 32,
   localparam int IW    = $clog2(N_DIM),
   localparam int VEC_W = N_DIM * ELEM_W
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic             rd_en,
   input logic             rd_col_mode,
   input logic [IW-1:0]    rd_index,
   input logic             rd_valid,
   input logic [VEC_W-1:0] rd_data
);

   // R6
   reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !rd_valid);

   // R3
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      rd_en |=> rd_valid);

   // R3
   valid_only_after_req_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> !rd_valid);

   // R7
   data_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));

   // R9
   diag_agree_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_en && $past(rd_en) && !$past(rd_col_mode) && rd_col_mode &&
       ($past(rd_index) == rd_index) && !$past(wr_en))
      |=> (rd_data[$past(rd_index)*ELEM_W +: ELEM_W] ==
           $past(rd_data[$past(rd_index)*ELEM_W +: ELEM_W])));

endmodule

bind tmat_skew_mem tmat_skew_mem_chk #(.N_DIM(N_DIM), .ELEM_W(ELEM_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .wr_en       (wr_en),
   .rd_en       (rd_en),
   .rd_col_mode (rd_col_mode),
   .rd_index    (rd_index),
   .rd_valid    (rd_valid),
   .rd_data     (rd_data)
);

// File: tb/tmat_skew_mem_test.sv
module tmat_skew_mem_test;

   localparam int N  = 16;
   localparam int W  = 32;
   localparam int IW = 4;
   localparam int VW = N * W;

   logic          clk = 1'b0;
   logic          rst;
   logic          wr_en;
   logic [IW-1:0] wr_row, wr_col;
   logic [W-1:0]  wr_data;
   logic          rd_en;
   logic          rd_col_mode;
   logic [IW-1:0] rd_index;
   logic          rd_valid;
   logic [VW-1:0] rd_data;

   always #2 clk = ~clk;   // 250 MHz

   tmat_skew_mem #(.N_DIM(N), .ELEM_W(W)) uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
      .wr_data(wr_data), .rd_en(rd_en), .rd_col_mode(rd_col_mode),
      .rd_index(rd_index), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [W-1:0] model [N][N];

   function automatic logic [W-1:0] pattern(int r, int c, int seed);
      return W'(seed * 65537 + r * 4099 + c * 131 + 7) ^ {8'(r), 8'(c), 16'h0};
   endfunction

   function automatic logic [VW-1:0] expect_vec(bit col_mode, int idx);
      logic [VW-1:0] v;
      for (int k = 0; k < N; k++) begin
         v[k*W +: W] = col_mode ? model[k][idx] : model[idx][k];
      end
      return v;
   endfunction

   task automatic check_bit(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic check_vec(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // All tasks are entered at a falling edge and leave at a falling edge.
   task automatic write_elem(int r, int c, logic [W-1:0] d);
      wr_en = 1'b1; wr_row = IW'(r); wr_col = IW'(c); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model[r][c] = d;
   endtask

   task automatic read_check(bit col_mode, int idx, string req);
      logic [VW-1:0] exp, held;
      exp = expect_vec(col_mode, idx);
      rd_en = 1'b1; rd_col_mode = col_mode; rd_index = IW'(idx);
      @(negedge clk);
      rd_en = 1'b0;
      check_bit({req, "/R3 valid"}, rd_valid, 1'b1);
      check_vec(req, rd_data, exp);
      held = rd_data;
      @(negedge clk);
      check_bit("R3 valid low when idle", rd_valid, 1'b0);
      check_vec("R7 hold", rd_data, held);
   endtask

   task automatic fill(int seed);
      for (int r = 0; r < N; r++) begin
         for (int c = 0; c < N; c++) begin
            write_elem(r, c, pattern(r, c, seed));
         end
      end
   endtask

   task automatic sweep();
      for (int i = 0; i < N; i++) read_check(1'b0, i, "R1 row read");
      for (int i = 0; i < N; i++) read_check(1'b1, i, "R2 column read");
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] oldv, newv;
      logic [VW-1:0] exp;
      rst = 1'b1; wr_en = 1'b0; wr_row = '0; wr_col = '0; wr_data = '0;
      rd_en = 1'b0; rd_col_mode = 1'b0; rd_index = '0;
      repeat (4) @(negedge clk);
      check_bit("R6 reset valid", rd_valid, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      check_bit("R6 valid after reset", rd_valid, 1'b0);

      fill(1);
      sweep();
      fill(2);
      sweep();

      // R5: write and read of the same element in one cycle.
      oldv = model[3][5];
      newv = 32'hDEAD_BEEF;
      exp  = expect_vec(1'b0, 3);
      wr_en = 1'b1; wr_row = 4'd3; wr_col = 4'd5; wr_data = newv;
      rd_en = 1'b1; rd_col_mode = 1'b0; rd_index = 4'd3;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      model[3][5] = newv;
      check_vec("R5 old data on collision", rd_data, exp);
      check_bit("R5 old lane value", rd_data[5*W +: W] == oldv, 1'b1);
      @(negedge clk);

      // R8: read in the cycle right after a write; R4 only that element moves.
      write_elem(9, 14, 32'h1234_5678);
      read_check(1'b1, 14, "R8 column read after write");
      read_check(1'b0, 9, "R4 row after single write");
      read_check(1'b1, 5, "R4 column after collision write");
      write_elem(15, 15, 32'hFFFF_0001);
      read_check(1'b0, 15, "R8 row read after write");

      // R9: back-to-back row and column reads of the diagonal.
      rd_en = 1'b1; rd_col_mode = 1'b0; rd_index = 4'd6;
      @(negedge clk);
      check_vec("R9 row before column", rd_data, expect_vec(1'b0, 6));
      rd_col_mode = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check_vec("R9 column after row", rd_data, expect_vec(1'b1, 6));
      check_bit("R9 diagonal lane", rd_data[6*W +: W] == model[6][6], 1'b1);
      @(negedge clk);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule